// File: doc/BRIEF.md
# Key-Value Slot Storage Controller with Key Confirmation

This block sits behind the tag directory of a key-value lookup pipeline. It accepts one request at a time: an operation, a full key, a value, a slot address and the directory's tentative hit flag. It then does the memory work the operation needs on a simple slot-wide memory port. A store writes the key and value into the slot. A fetch reads the slot back. A removal makes no memory access. The directory hit is only a hint, because it is derived from a hash. A fetch returns data only after the complete stored key has been compared with the requested key and found equal.

A small direct-mapped line buffer holds recently read slots, so a repeated fetch needs no memory read. A store to a buffered slot writes through and refreshes that line, so later fetches never see stale contents. Each fetch ends with one plain hit/miss verdict pulse for the unit that steers requests. Verdicts come out in request order.

The request input, the memory request and the reply output are valid/ready channels. A transfer happens on a clock edge where both valid and ready are high. Once raised, valid and the payload stay unchanged until that edge. `req_ready` is high only while the block is idle, so at most one request is in flight. The memory port applies back-pressure through `mem_req_ready`. Read data returns on `mem_rsp_valid` after any delay and cannot be refused. The reply consumer may hold `rep_ready` low for any number of cycles.

Top module: `kvslot_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, `req_ready` is 1 and `mem_req_valid`, `rep_valid` and `vrd_valid` are 0. A request is taken only on an edge with `req_valid` and `req_ready` both high.
- R2: `req_op` is encoded as 2'b00 fetch, 2'b01 store, 2'b10 remove, and 2'b11 is handled exactly like remove.
- R3: A fetch with `req_hit`=0 issues no memory request. It gives `vrd_valid`=1 with `vrd_hit`=0 in the cycle after acceptance.
- R4: A fetch with `req_hit`=1 whose slot is not in the line buffer issues exactly one memory read (`mem_we`=0) at `req_addr`. The key is taken from read-data bits [KEY_W-1:0] and the value from bits [SLOT_W-1:KEY_W].
- R5: When the stored key equals the requested key, exactly one reply carries the stored key and value. A verdict with `vrd_hit`=1 follows in the cycle after the reply transfer.
- R6: When the stored key differs from the requested key in any bit, no reply is produced and the verdict has `vrd_hit`=0.
- R7: A store issues exactly one memory write at `req_addr` with `mem_wdata` = {value, key}, the key in the low KEY_W bits. It produces no verdict and no reply.
- R8: A remove (op 2'b10 or 2'b11) makes no memory access and produces no reply and no verdict. It leaves stored data unchanged.
- R9: The line buffer is direct-mapped with LINES lines, indexed by `req_addr` mod LINES. Every memory read fills its line. A fetch with `req_hit`=1 whose slot is held there issues no memory read.
- R10: A store to a slot held in the line buffer updates that line, so a later fetch served from the buffer returns the stored data.
- R11: While `mem_req_valid` or `rep_valid` is high and its ready is low, valid stays high and the address, write flag and payload stay unchanged.
- R12: Every accepted fetch produces exactly one single-cycle verdict pulse, before the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_op | input | 2 | Operation code |
| req_key | input | KEY_W | Requested key |
| req_val | input | VAL_W | Value for a store |
| req_addr | input | ADDR_W | Slot address from the directory |
| req_hit | input | 1 | Tentative directory hit |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Slot address to memory |
| mem_wdata | output | SLOT_W | Slot write data {value, key} |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | SLOT_W | Slot read data |
| rep_valid | output | 1 | Reply valid |
| rep_ready | input | 1 | Reply ready |
| rep_key | output | KEY_W | Reply key |
| rep_val | output | VAL_W | Reply value |
| vrd_valid | output | 1 | Verdict pulse, one per fetch |
| vrd_hit | output | 1 | Verdict: 1 hit, 0 miss |

## Verification
Fetches are tried with four kinds of input:
- A cleared directory flag, which separates the early miss from a read.
- The exact stored key, which confirms the key and value fields of the slot.
- A key wrong in only its top bit or only its bottom bit, which shows that the whole key width is compared rather than a part of it.
- A key wrong in a random bit.

Repeated fetches, fetches to addresses that share a buffer line, and stores followed by fetches tell a buffer hit apart from a refill and from stale data. The bench counts memory reads against its own model of the buffer. Removes with both encodings, random memory and reply back-pressure, and random mixes of all operations check that no stray access, reply or verdict appears.

// File: rtl/kvs_pkg.sv
package kvs_pkg;

  typedef enum logic [1:0] {
    OP_FETCH  = 2'b00,
    OP_STORE  = 2'b01,
    OP_REMOVE = 2'b10,
    OP_RSVD   = 2'b11
  } kvs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RDREQ,
    ST_RDWAIT,
    ST_CMP,
    ST_REPLY,
    ST_VERDICT,
    ST_WRITE
  } kvs_st_e;

endpackage

// File: rtl/kvs_key_cmp.sv
module kvs_key_cmp #(
  parameter int KEY_BYTES   = 64,
  parameter int CHUNK_BYTES = 8,
  localparam int KEY_W      = KEY_BYTES * 8,
  localparam int NCHUNK     = KEY_BYTES / CHUNK_BYTES,
  localparam int CW         = CHUNK_BYTES * 8
) (
  input  logic [KEY_W-1:0] key_a,
  input  logic [KEY_W-1:0] key_b,
  output logic             same
);

  logic [NCHUNK-1:0] chunk_eq;

  // split the wide compare into chunks; the AND tree stays shallow
  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunk_eq[g] = (key_a[g*CW +: CW] == key_b[g*CW +: CW]);
  end

  assign same = &chunk_eq;

endmodule

// File: rtl/kvs_line_buf.sv
module kvs_line_buf #(
  parameter int ADDR_W = 10,
  parameter int SLOT_W = 4096,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic [SLOT_W-1:0] fill_data,
  input  logic              upd_en,
  input  logic [SLOT_W-1:0] upd_data
);

  logic [LINES-1:0]  line_vld;
  logic [TAG_W-1:0]  line_tag  [LINES];
  logic [SLOT_W-1:0] line_data [LINES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;

  assign idx = addr[IDX_W-1:0];
  assign tag = addr[ADDR_W-1:IDX_W];

  assign lk_hit  = line_vld[idx] && (line_tag[idx] == tag);
  assign lk_data = line_data[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_vld <= '0;
      for (int i = 0; i < LINES; i++) line_tag[i] <= '0;
    end else if (fill_en) begin
      line_vld[idx] <= 1'b1;
      line_tag[idx] <= tag;
    end
  end

  // data has no reset: only read when the valid bit is set
  always_ff @(posedge clk) begin
    if (fill_en) begin
      line_data[idx] <= fill_data;
    end else if (upd_en && lk_hit) begin
      line_data[idx] <= upd_data;
    end
  end

endmodule

// File: rtl/kvslot_ctrl.sv
module kvslot_ctrl
  import kvs_pkg::*;
#(
  parameter int KEY_BYTES   = 64,
  parameter int VAL_BYTES   = 448,
  parameter int ADDR_W      = 10,
  parameter int LINES       = 4,
  parameter int CHUNK_BYTES = 8,
  localparam int KEY_W      = KEY_BYTES * 8,
  localparam int VAL_W      = VAL_BYTES * 8,
  localparam int SLOT_W     = KEY_W + VAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [KEY_W-1:0]  req_key,
  input  logic [VAL_W-1:0]  req_val,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SLOT_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [SLOT_W-1:0] mem_rdata,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [KEY_W-1:0]  rep_key,
  output logic [VAL_W-1:0]  rep_val,
  output logic              vrd_valid,
  output logic              vrd_hit
);

  kvs_st_e           st;
  logic [KEY_W-1:0]  key_q;
  logic [VAL_W-1:0]  val_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SLOT_W-1:0] slot_q;
  logic              hit_q;

  logic              take;
  logic              lb_hit;
  logic [SLOT_W-1:0] lb_data;
  logic              lb_fill;
  logic              lb_upd;
  logic              key_same;

  assign req_ready = (st == ST_IDLE);
  assign take      = req_valid && req_ready;

  assign lb_fill = (st == ST_RDWAIT) && mem_rsp_valid;
  assign lb_upd  = (st == ST_WRITE) && mem_req_ready;

  kvs_line_buf #(
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W),
    .LINES  (LINES)
  ) u_lbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr_q),
    .lk_hit    (lb_hit),
    .lk_data   (lb_data),
    .fill_en   (lb_fill),
    .fill_data (mem_rdata),
    .upd_en    (lb_upd),
    .upd_data  (mem_wdata)
  );

  kvs_key_cmp #(
    .KEY_BYTES   (KEY_BYTES),
    .CHUNK_BYTES (CHUNK_BYTES)
  ) u_kcmp (
    .key_a (slot_q[KEY_W-1:0]),
    .key_b (key_q),
    .same  (key_same)
  );

  // request capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= '0;
      val_q  <= '0;
      addr_q <= '0;
    end else if (take) begin
      key_q  <= req_key;
      val_q  <= req_val;
      addr_q <= req_addr;
    end
  end

  // slot data holder: from the line buffer or from memory
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (st == ST_LOOK && lb_hit) begin
      slot_q <= lb_data;
    end else if (lb_fill) begin
      slot_q <= mem_rdata;
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      hit_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (take) begin
            hit_q <= 1'b0;
            case (kvs_op_e'(req_op))
              OP_FETCH: st <= req_hit ? ST_LOOK : ST_VERDICT;
              OP_STORE: st <= ST_WRITE;
              default:  st <= ST_IDLE;
            endcase
          end
        end
        ST_LOOK:    st <= lb_hit ? ST_CMP : ST_RDREQ;
        ST_RDREQ:   if (mem_req_ready) st <= ST_RDWAIT;
        ST_RDWAIT:  if (mem_rsp_valid) st <= ST_CMP;
        ST_CMP:     st <= key_same ? ST_REPLY : ST_VERDICT;
        ST_REPLY: begin
          if (rep_ready) begin
            hit_q <= 1'b1;
            st    <= ST_VERDICT;
          end
        end
        ST_VERDICT: st <= ST_IDLE;
        ST_WRITE:   if (mem_req_ready) st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == ST_RDREQ) || (st == ST_WRITE);
  assign mem_we        = (st == ST_WRITE);
  assign mem_addr      = addr_q;
  assign mem_wdata     = {val_q, key_q};

  assign rep_valid = (st == ST_REPLY);
  assign rep_key   = slot_q[KEY_W-1:0];
  assign rep_val   = slot_q[SLOT_W-1:KEY_W];

  assign vrd_valid = (st == ST_VERDICT);
  assign vrd_hit   = hit_q;

endmodule

// File: rtl/kvslot_ctrl_chk.sv
module kvslot_ctrl_chk #(
  parameter int KEY_W  = 512,
  parameter int VAL_W  = 3584,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [KEY_W-1:0]  req_key,
  input logic [VAL_W-1:0]  req_val,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [KEY_W+VAL_W-1:0] mem_wdata,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic [KEY_W-1:0]  rep_key,
  input logic [VAL_W-1:0]  rep_val,
  input logic              vrd_valid,
  input logic              vrd_hit
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rep_valid && !vrd_valid)); // R1

  AST_EARLY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b00 && !req_hit) |=> (vrd_valid && !vrd_hit && !mem_req_valid)); // R3

  AST_HIT_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd_valid && vrd_hit) |-> $past(rep_valid && rep_ready)); // R5

  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b01) |=> (mem_req_valid && mem_we && mem_addr == $past(req_addr)
                                  && mem_wdata == $past({req_val, req_key}))); // R7

  AST_REMOVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op[1]) |=> (req_ready && !mem_req_valid && !vrd_valid)); // R8

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)
                                           && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_REP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_key) && $stable(rep_val))); // R11

  AST_VRD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid |=> !vrd_valid); // R12

endmodule

bind kvslot_ctrl kvslot_ctrl_chk #(
  .KEY_W  (KEY_W),
  .VAL_W  (VAL_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_op        (req_op),
  .req_key       (req_key),
  .req_val       (req_val),
  .req_addr      (req_addr),
  .req_hit       (req_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .rep_valid     (rep_valid),
  .rep_ready     (rep_ready),
  .rep_key       (rep_key),
  .rep_val       (rep_val),
  .vrd_valid     (vrd_valid),
  .vrd_hit       (vrd_hit)
);

// File: tb/kvslot_ctrl_test.sv
module kvslot_ctrl_test;

  localparam int KB     = 64;
  localparam int VB     = 448;
  localparam int AW     = 6;
  localparam int NL     = 4;
  localparam int KEY_W  = KB * 8;
  localparam int VAL_W  = VB * 8;
  localparam int SLOT_W = KEY_W + VAL_W;
  localparam int NSLOT  = 1 << AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_op = 2'b00;
  logic [KEY_W-1:0]  req_key = '0;
  logic [VAL_W-1:0]  req_val = '0;
  logic [AW-1:0]     req_addr = '0;
  logic              req_hit = 1'b0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [SLOT_W-1:0] mem_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [SLOT_W-1:0] mem_rdata = '0;
  logic              rep_valid;
  logic              rep_ready = 1'b0;
  logic [KEY_W-1:0]  rep_key;
  logic [VAL_W-1:0]  rep_val;
  logic              vrd_valid;
  logic              vrd_hit;

  always #10 clk = ~clk;

  kvslot_ctrl #(.KEY_BYTES(KB), .VAL_BYTES(VB), .ADDR_W(AW), .LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_key(req_key), .req_val(req_val), .req_addr(req_addr), .req_hit(req_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_key(rep_key), .rep_val(rep_val),
    .vrd_valid(vrd_valid), .vrd_hit(vrd_hit)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, rep_cnt = 0, vrd_cnt = 0, n_fetch = 0;
  int rsp_wait = 0;
  logic [AW-1:0]     last_raddr, last_waddr;
  logic [KEY_W-1:0]  last_rkey;
  logic [VAL_W-1:0]  last_rval;
  logic              last_vhit;
  logic [SLOT_W-1:0] bmem [NSLOT];

  // bench scoreboard: seeds of what each slot should hold
  int unsigned sb_kseed [NSLOT];
  int unsigned sb_vseed [NSLOT];
  // bench model of the direct-mapped line buffer (R9)
  bit          lbm_vld  [NL];
  logic [AW-1:0] lbm_addr [NL];

  function automatic logic [KEY_W-1:0] mk_key(input int unsigned s);
    logic [KEY_W-1:0] r;
    for (int i = 0; i < KEY_W / 32; i++)
      r[i*32 +: 32] = (s * 32'h9E3779B1) ^ (i * 32'h85EBCA6B) ^ 32'h5BD1E995;
    return r;
  endfunction

  function automatic logic [VAL_W-1:0] mk_val(input int unsigned s);
    logic [VAL_W-1:0] r;
    for (int i = 0; i < VAL_W / 32; i++)
      r[i*32 +: 32] = (s * 32'hC2B2AE35) ^ (i * 32'h27D4EB2F) ^ 32'h165667B1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory model, reply sink and verdict monitor, all at the falling edge
  always @(negedge clk) begin
    if (rsp_wait > 0) begin
      rsp_wait--;
      mem_rsp_valid <= (rsp_wait == 0);
    end else begin
      mem_rsp_valid <= 1'b0;
    end
    mem_req_ready <= ($urandom % 10) < 7;
    rep_ready     <= ($urandom % 10) < 6;
  end

  always @(negedge clk) begin
    #1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        bmem[mem_addr] = mem_wdata;
        wr_cnt++;
        last_waddr = mem_addr;
      end else begin
        mem_rdata <= bmem[mem_addr];
        rd_cnt++;
        last_raddr = mem_addr;
        rsp_wait = 1 + ($urandom % 3);
      end
    end
    if (rep_valid && rep_ready) begin
      rep_cnt++;
      last_rkey = rep_key;
      last_rval = rep_val;
    end
    if (vrd_valid) begin
      vrd_cnt++;
      last_vhit = vrd_hit;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input bit h,
                       input logic [KEY_W-1:0] k, input logic [VAL_W-1:0] v);
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_hit = h; req_key = k; req_val = v;
    while (1) begin
      ok = req_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    #2 req_valid = 1'b0;
  endtask

  task automatic do_fetch(input logic [AW-1:0] a, input bit h, input logic [KEY_W-1:0] k,
                          input string rq);
    int rb = rd_cnt, pb = rep_cnt, vb = vrd_cnt;
    int idx = int'(a) % NL;
    bit exp_rd = h && !(lbm_vld[idx] && lbm_addr[idx] == a);
    bit exp_match = h && (k == mk_key(sb_kseed[a]));
    n_fetch++;
    issue(2'b00, a, h, k, '0);
    wait (vrd_cnt != vb);
    @(negedge clk); #3;
    if (exp_rd) begin
      lbm_vld[idx] = 1'b1;
      lbm_addr[idx] = a;
    end
    chk(rd_cnt - rb == (exp_rd ? 1 : 0), rq, "memory reads (R4 R9)", 64'(rd_cnt - rb), 64'(exp_rd));
    if (exp_rd) chk(last_raddr == a, rq, "read address (R4)", 64'(last_raddr), 64'(a));
    chk(vrd_cnt - vb == 1, rq, "verdict count (R12)", 64'(vrd_cnt - vb), 64'd1);
    chk(last_vhit == exp_match, rq, "verdict hit (R3 R5 R6)", 64'(last_vhit), 64'(exp_match));
    chk(rep_cnt - pb == (exp_match ? 1 : 0), rq, "reply count (R5 R6)",
        64'(rep_cnt - pb), 64'(exp_match));
    if (exp_match) begin
      chk(last_rkey == mk_key(sb_kseed[a]), rq, "reply key (R5)",
          last_rkey[63:0], mk_key(sb_kseed[a]) & 64'hFFFF_FFFF_FFFF_FFFF);
      chk(last_rval == mk_val(sb_vseed[a]), rq, "reply value (R5 R10)",
          last_rval[63:0], mk_val(sb_vseed[a]) & 64'hFFFF_FFFF_FFFF_FFFF);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input int unsigned ks, input int unsigned vs,
                          input string rq);
    int wb = wr_cnt, vb = vrd_cnt, pb = rep_cnt;
    logic [SLOT_W-1:0] exp_slot = {mk_val(vs), mk_key(ks)};
    issue(2'b01, a, 1'b1, mk_key(ks), mk_val(vs));
    wait (wr_cnt != wb);
    repeat (2) @(negedge clk);
    #3;
    sb_kseed[a] = ks;
    sb_vseed[a] = vs;
    chk(wr_cnt - wb == 1, rq, "write count (R7)", 64'(wr_cnt - wb), 64'd1);
    chk(last_waddr == a, rq, "write address (R7)", 64'(last_waddr), 64'(a));
    chk(bmem[a] == exp_slot, rq, "write layout (R7)", bmem[a][63:0], exp_slot[63:0]);
    chk(vrd_cnt == vb && rep_cnt == pb, rq, "no verdict on store (R7)",
        64'(vrd_cnt - vb), 64'd0);
  endtask

  task automatic do_remove(input logic [1:0] op, input logic [AW-1:0] a, input string rq);
    int rb = rd_cnt, wb = wr_cnt, vb = vrd_cnt, pb = rep_cnt;
    issue(op, a, 1'b1, mk_key(sb_kseed[a]), '1);
    repeat (4) @(negedge clk);
    #3;
    chk(rd_cnt == rb && wr_cnt == wb, rq, "no memory access on remove (R2 R8)",
        64'(rd_cnt - rb + wr_cnt - wb), 64'd0);
    chk(vrd_cnt == vb && rep_cnt == pb, rq, "no verdict on remove (R8)",
        64'(vrd_cnt - vb + rep_cnt - pb), 64'd0);
    chk(req_ready == 1'b1, rq, "idle after remove (R1)", 64'(req_ready), 64'd1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  logic [KEY_W-1:0] one_k;

  initial begin
    void'($urandom(32'd20250611));
    one_k = 1;
    for (int a = 0; a < NSLOT; a++) begin
      bmem[a] = {mk_val(32'(a) + 500), mk_key(32'(a))};
      sb_kseed[a] = 32'(a);
      sb_vseed[a] = 32'(a) + 500;
    end
    for (int i = 0; i < NL; i++) begin
      lbm_vld[i] = 1'b0;
      lbm_addr[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    chk(!mem_req_valid && !rep_valid && !vrd_valid, "R1", "reset outputs quiet",
        64'({mem_req_valid, rep_valid, vrd_valid}), 64'd0);

    // directed corner cases
    do_fetch(6'd5, 1'b0, mk_key(5), "R3");
    do_fetch(6'd5, 1'b1, mk_key(5), "R4");
    do_fetch(6'd5, 1'b1, mk_key(5), "R9");
    do_fetch(6'd9, 1'b1, mk_key(9) ^ (one_k << (KEY_W - 1)), "R6");
    do_fetch(6'd9, 1'b1, mk_key(9) ^ one_k, "R6");
    do_store(6'd5, 200, 300, "R7");
    do_fetch(6'd5, 1'b1, mk_key(200), "R10");
    do_remove(2'b10, 6'd5, "R8");
    do_remove(2'b11, 6'd5, "R2");
    do_fetch(6'd5, 1'b1, mk_key(200), "R8");
    do_fetch(6'd1, 1'b1, mk_key(1), "R9");
    do_fetch(6'd5, 1'b1, mk_key(200), "R9");
    do_store(6'd13, 77, 78, "R7");
    do_fetch(6'd13, 1'b1, mk_key(77), "R5");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom % 10);
      logic [AW-1:0] a = AW'($urandom % NSLOT);
      if (r < 6) begin
        bit h = ($urandom % 5) != 0;
        logic [KEY_W-1:0] k = mk_key(sb_kseed[a]);
        if (($urandom % 4) == 0) k = k ^ (one_k << ($urandom % KEY_W));
        do_fetch(a, h, k, "R5");
      end else if (r < 8) begin
        do_store(a, 32'(1000 + n), 32'(5000 + n), "R10");
      end else begin
        do_remove((($urandom % 2) == 0) ? 2'b10 : 2'b11, a, "R8");
      end
    end

    chk(vrd_cnt == n_fetch, "R12", "one verdict per fetch", 64'(vrd_cnt), 64'(n_fetch));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule